// File: doc/BRIEF.md
# Rectangle Transfer Address Generator

This block walks a rectangular region of a 1024 by 512 frame buffer of 16-bit pixels. A request carries a position word, a size word and a direction. The block then turns host data words into pixel writes, or pixel reads into host data words. Every 32-bit data word holds two pixels: the lower half is the first pixel and the upper half is the second.

Pixels are visited left to right along each row, then row by row downward. Both coordinates wrap around the edges of the buffer. A transfer may stall between words for any length of time, and the block keeps its place in a row that is only partly done.

A write can force the top bit of every stored pixel to 1. A read raises an image-ready flag that holds until the last word has been handed back. A one-cycle done pulse marks the end of each transfer. A new request restarts the walk at once, even in the middle of a transfer.

Top module: `rect_xfer_agen`

## Requirements
- R1: The start column is `req_pos[9:0]` and the start row is `req_pos[24:16]`. All other position bits are ignored.
- R2: The width is `req_size[9:0]` and the height is `req_size[24:16]`. A width field of 0 means 1024 columns and a height field of 0 means 512 rows.
- R3: Pixels are visited left to right within a row, then top to bottom. Each word's low half (bits 15:0) goes first and its high half (bits 31:16) second. The memory address is row*1024 + column.
- R4: The column wraps modulo 1024 past the right edge, and the row wraps modulo 512 past the bottom edge.
- R5: On a write requested with `req_set_mask`=1, bit 15 of every stored pixel is 1. With `req_set_mask`=0 the pixel is stored unchanged.
- R6: When the pixel count is odd, the high half of the final write word produces no memory write. On a read, the high half of the final word is returned as zero.
- R7: On a read, each `rd_pull` accepted while `word_ready`=1 yields one `rd_valid` pulse. `rd_word[15:0]` holds the earlier pixel and `rd_word[31:16]` the later one. `img_ready` is high from the read request until the cycle that delivers the final word, and low in that cycle.
- R8: `done` pulses for exactly one cycle, and `busy` is 0 in that cycle. On a write, the pulse comes in the cycle after the last memory write. On a read, it comes in the same cycle as the final `rd_valid`.
- R9: A request reloads all position, size and count state even when a transfer is unfinished. The unfinished transfer produces no further accesses and no `done`.
- R10: After reset, `busy`, `img_ready`, `done`, `word_ready`, `rd_valid`, `mem_we` and `mem_re` are all 0.
- R11: `mem_we` and `mem_re` are never high together. No memory access happens while `word_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts a new transfer this cycle |
| req_pos | input | 32 | Start position word |
| req_size | input | 32 | Size word |
| req_read | input | 1 | 1 = read to host, 0 = write from host |
| req_set_mask | input | 1 | Force bit 15 of written pixels |
| wr_valid | input | 1 | Host write word is present |
| wr_word | input | 32 | Host write word (two pixels) |
| word_ready | output | 1 | Block is waiting for the next word or pull |
| rd_pull | input | 1 | Host asks for the next read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_word` |
| rd_word | output | 32 | Read word (two pixels) |
| mem_addr | output | 20 | Pixel address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns the next cycle |
| mem_wdata | output | 16 | Pixel written |
| mem_rdata | input | 16 | Pixel read, one cycle after `mem_re` |
| busy | output | 1 | A transfer is in progress |
| img_ready | output | 1 | A read transfer still has data to deliver |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with its default parameters: 10 column bits, 9 row bits, a 20-bit address and 16-bit pixels. With these values, both wrap edges are reached by rectangles placed near column 1023 and row 511.

A zero width field gives a full 1024-pixel row, and a zero height field gives a full 512-row column. Both fit within a short run, so the full-span decoding is exercised at its real extent rather than on a shrunken buffer.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  // Transfer engine states.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PIX0,
    ST_PIX1,
    ST_GATHER
  } rxa_state_e;

  // Bit position of the row field inside the position and size words.
  localparam int ROW_FIELD_LSB = 16;

endpackage

// File: rtl/rxa_req_decode.sv
module rxa_req_decode #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int ROW_LSB = 16
) (
  input  logic [31:0]       pos,
  input  logic [31:0]       size,
  output logic [X_BITS-1:0] x0,
  output logic [Y_BITS-1:0] y0,
  output logic [X_BITS-1:0] wm1,
  output logic [Y_BITS-1:0] hm1
);

  // Span minus one, modulo the field width: a zero field becomes the full span.
  function automatic logic [X_BITS-1:0] col_span_m1(input logic [X_BITS-1:0] f);
    return f - X_BITS'(1);
  endfunction

  function automatic logic [Y_BITS-1:0] row_span_m1(input logic [Y_BITS-1:0] f);
    return f - Y_BITS'(1);
  endfunction

  wire unused_req_bits = ^{pos, size};

  assign x0  = pos[X_BITS-1:0];
  assign y0  = pos[ROW_LSB +: Y_BITS];
  assign wm1 = col_span_m1(size[X_BITS-1:0]);
  assign hm1 = row_span_m1(size[ROW_LSB +: Y_BITS]);

endmodule

// File: rtl/rxa_walker.sv
module rxa_walker #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [X_BITS-1:0] x0_in,
  input  logic [Y_BITS-1:0] y0_in,
  input  logic [X_BITS-1:0] wm1_in,
  input  logic [Y_BITS-1:0] hm1_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_pix
);

  localparam int PAD_W = ADDR_W - X_BITS - Y_BITS;

  logic [X_BITS-1:0] x0_q, wm1_q, col_q;
  logic [Y_BITS-1:0] y0_q, hm1_q, row_q;
  logic [X_BITS-1:0] cur_x;
  logic [Y_BITS-1:0] cur_y;
  logic              row_end;

  // Buffer address: row times row length plus column, zero-extended.
  function automatic logic [ADDR_W-1:0] pix_addr(input logic [X_BITS-1:0] x,
                                                 input logic [Y_BITS-1:0] y);
    return {{PAD_W{1'b0}}, y, x};
  endfunction

  // Coordinate sums truncate to the field width, which gives the edge wrap.
  assign cur_x    = x0_q + col_q;
  assign cur_y    = y0_q + row_q;
  assign addr     = pix_addr(cur_x, cur_y);
  assign row_end  = (col_q == wm1_q);
  assign last_pix = row_end && (row_q == hm1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0_q  <= '0;
      y0_q  <= '0;
      wm1_q <= '0;
      hm1_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (load) begin
      x0_q  <= x0_in;
      y0_q  <= y0_in;
      wm1_q <= wm1_in;
      hm1_q <= hm1_in;
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + Y_BITS'(1);
      end else begin
        col_q <= col_q + X_BITS'(1);
      end
    end
  end

endmodule

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic               req_set_mask,
  input  logic               wr_valid,
  input  logic [2*PIX_W-1:0] wr_word,
  input  logic               rd_pull,
  input  logic [PIX_W-1:0]   mem_rdata,
  input  logic               last_pix,
  output logic               word_ready,
  output logic               step,
  output logic               mem_we,
  output logic               mem_re,
  output logic [PIX_W-1:0]   mem_wdata,
  output logic               rd_valid,
  output logic [2*PIX_W-1:0] rd_word,
  output logic               done,
  output logic               busy,
  output logic               img_ready,
  output logic               dir_rd,
  output logic               mask_q
);

  rxa_state_e         state;
  logic [2*PIX_W-1:0] word_q;
  logic [PIX_W-1:0]   lo_q;
  logic               pair_q;
  logic               last_q;
  logic               word_go;
  logic [PIX_W-1:0]   half_sel;

  assign word_ready = (state == ST_WAIT);
  assign word_go    = word_ready && (dir_rd ? rd_pull : wr_valid);
  assign step       = (state == ST_PIX0) || (state == ST_PIX1);
  assign mem_we     = step && !dir_rd;
  assign mem_re     = step && dir_rd;
  assign busy       = (state != ST_IDLE);
  assign half_sel   = (state == ST_PIX1) ? word_q[2*PIX_W-1:PIX_W] : word_q[PIX_W-1:0];
  assign mem_wdata  = half_sel | (PIX_W'(mask_q) << (PIX_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_rd    <= 1'b0;
      mask_q    <= 1'b0;
      word_q    <= '0;
      lo_q      <= '0;
      pair_q    <= 1'b0;
      last_q    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_word   <= '0;
      done      <= 1'b0;
      img_ready <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (req_valid) begin
        state     <= ST_WAIT;
        dir_rd    <= req_read;
        mask_q    <= req_set_mask && !req_read;
        img_ready <= req_read;
        pair_q    <= 1'b0;
        last_q    <= 1'b0;
      end else begin
        case (state)
          ST_WAIT: begin
            if (word_go) begin
              state <= ST_PIX0;
              if (!dir_rd) word_q <= wr_word;
            end
          end
          ST_PIX0: begin
            pair_q <= 1'b0;
            last_q <= last_pix;
            if (last_pix) begin
              if (dir_rd) begin
                state <= ST_GATHER;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              state <= ST_PIX1;
            end
          end
          ST_PIX1: begin
            pair_q <= 1'b1;
            lo_q   <= mem_rdata;
            last_q <= last_pix;
            if (dir_rd) begin
              state <= ST_GATHER;
            end else if (last_pix) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_GATHER: begin
            rd_valid <= 1'b1;
            rd_word  <= pair_q ? {mem_rdata, lo_q} : {{PIX_W{1'b0}}, mem_rdata};
            if (last_q) begin
              state     <= ST_IDLE;
              done      <= 1'b1;
              img_ready <= 1'b0;
            end else begin
              state <= ST_WAIT;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rect_xfer_agen.sv
module rect_xfer_agen #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int ADDR_W = 20,
  parameter int PIX_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_pos,
  input  logic [31:0]        req_size,
  input  logic               req_read,
  input  logic               req_set_mask,
  input  logic               wr_valid,
  input  logic [2*PIX_W-1:0] wr_word,
  output logic               word_ready,
  input  logic               rd_pull,
  output logic               rd_valid,
  output logic [2*PIX_W-1:0] rd_word,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic               busy,
  output logic               img_ready,
  output logic               done
);

  logic [X_BITS-1:0] dec_x0, dec_wm1;
  logic [Y_BITS-1:0] dec_y0, dec_hm1;
  logic              last_pix;
  logic              pix_step;
  logic              xfer_last;
  logic              dir_rd;
  logic              mask_q;

  rxa_req_decode #(
    .X_BITS (X_BITS),
    .Y_BITS (Y_BITS),
    .ROW_LSB(rxa_pkg::ROW_FIELD_LSB)
  ) u_dec (
    .pos (req_pos),
    .size(req_size),
    .x0  (dec_x0),
    .y0  (dec_y0),
    .wm1 (dec_wm1),
    .hm1 (dec_hm1)
  );

  rxa_walker #(
    .X_BITS(X_BITS),
    .Y_BITS(Y_BITS),
    .ADDR_W(ADDR_W)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (req_valid),
    .x0_in   (dec_x0),
    .y0_in   (dec_y0),
    .wm1_in  (dec_wm1),
    .hm1_in  (dec_hm1),
    .step    (pix_step),
    .addr    (mem_addr),
    .last_pix(last_pix)
  );

  rxa_ctrl #(
    .PIX_W(PIX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_read    (req_read),
    .req_set_mask(req_set_mask),
    .wr_valid    (wr_valid),
    .wr_word     (wr_word),
    .rd_pull     (rd_pull),
    .mem_rdata   (mem_rdata),
    .last_pix    (last_pix),
    .word_ready  (word_ready),
    .step        (pix_step),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_wdata   (mem_wdata),
    .rd_valid    (rd_valid),
    .rd_word     (rd_word),
    .done        (done),
    .busy        (busy),
    .img_ready   (img_ready),
    .dir_rd      (dir_rd),
    .mask_q      (mask_q)
  );

  // Event: the final pixel of the rectangle is being accessed this cycle.
  assign xfer_last = pix_step && last_pix;

endmodule

// File: rtl/rect_xfer_agen_chk.sv
module rect_xfer_agen_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             mem_we,
  input logic             mem_re,
  input logic [PIX_W-1:0] mem_wdata,
  input logic             mask_q,
  input logic             done,
  input logic             busy,
  input logic             img_ready,
  input logic             word_ready,
  input logic             dir_rd,
  input logic             pix_step,
  input logic             xfer_last
);

  // R11
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R11
  wait_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !(mem_we || mem_re));

  // R5
  mask_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mask_q) |-> mem_wdata[PIX_W-1]);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  write_done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_last && !dir_rd && !req_valid) |=> done);

  // R7
  img_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> busy);

  // R11
  step_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_step |-> (mem_we || mem_re));

endmodule

bind rect_xfer_agen rect_xfer_agen_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_wdata (mem_wdata),
  .mask_q    (mask_q),
  .done      (done),
  .busy      (busy),
  .img_ready (img_ready),
  .word_ready(word_ready),
  .dir_rd    (dir_rd),
  .pix_step  (pix_step),
  .xfer_last (xfer_last)
);

// File: tb/rect_xfer_agen_test.sv
module rect_xfer_agen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_pos = '0;
  logic [31:0] req_size = '0;
  logic        req_read = 1'b0;
  logic        req_set_mask = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        word_ready;
  logic        rd_pull = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic [19:0] mem_addr;
  logic        mem_we, mem_re;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        busy, img_ready, done;

  always #10 clk = ~clk;

  rect_xfer_agen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pos(req_pos),
    .req_size(req_size), .req_read(req_read), .req_set_mask(req_set_mask),
    .wr_valid(wr_valid), .wr_word(wr_word), .word_ready(word_ready),
    .rd_pull(rd_pull), .rd_valid(rd_valid), .rd_word(rd_word),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .img_ready(img_ready), .done(done)
  );

  int checks = 0;
  int fails = 0;
  bit reported = 1'b0;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  // Background content for never-written pixels.
  function automatic logic [15:0] bg(int a);
    return 16'((a * 7) ^ 32'h3c5a);
  endfunction

  function automatic logic [31:0] wdat(int s);
    return 32'(s * 32'h9e3779b1 + 32'h1234);
  endfunction

  // Frame buffer memory with a one-cycle read latency.
  logic [15:0] fb [int];
  always @(posedge clk) begin
    if (mem_we) fb[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= fb.exists(int'(mem_addr)) ? fb[int'(mem_addr)] : bg(int'(mem_addr));
  end

  // Reference model state.
  logic [15:0] mdl_fb [int];
  int          pix_a[$];
  int          exp_a[$];
  logic [15:0] exp_d[$];
  int          mdl_left = 0;
  bit          exp_done_next = 1'b0;
  bit          allow_done = 1'b0;

  function automatic logic [15:0] mdl_pix(int a);
    return mdl_fb.exists(a) ? mdl_fb[a] : bg(a);
  endfunction

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && mem_re) chk(1'b0, "R11 we and re together", 32'd1, 32'd0);
      if (word_ready && (mem_we || mem_re)) chk(1'b0, "R11 access while waiting", 32'd1, 32'd0);
      if (exp_done_next) begin
        chk(done == 1'b1, "R8 done after last write", 32'(done), 32'd1);
        chk(busy == 1'b0, "R8 idle at done", 32'(busy), 32'd0);
        exp_done_next = 1'b0;
      end else if (done && !allow_done) begin
        chk(1'b0, "R8/R9 unexpected done", 32'd1, 32'd0);
      end
      if (mem_we) begin
        if (exp_a.size() == 0) begin
          chk(1'b0, "R6/R9 unexpected write", 32'(mem_addr), 32'hffffffff);
        end else begin
          int          ea;
          logic [15:0] ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(int'(mem_addr) == ea, "R3 write address", 32'(mem_addr), 32'(ea));
          chk(mem_wdata == ed, "R5 write data", 32'(mem_wdata), 32'(ed));
          mdl_left--;
          if (mdl_left == 0) exp_done_next = 1'b1;
        end
      end
    end
  end

  // Issues a request at a negedge; ends at the following negedge.
  task automatic issue(int x, int y, int wf, int hf, bit rd, bit mask);
    int w, h;
    w = (wf % 1024 == 0) ? 1024 : wf % 1024;
    h = (hf % 512 == 0) ? 512 : hf % 512;
    pix_a.delete();
    exp_a.delete();
    exp_d.delete();
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        pix_a.push_back(((y + r) % 512) * 1024 + ((x + c) % 1024));
    mdl_left = rd ? -1 : w * h;
    // Junk in the unused position and size bits must be ignored (R1, R2).
    req_pos      = {7'h55, 9'(y), 6'h2a, 10'(x)};
    req_size     = {7'h33, 9'(hf), 6'h15, 10'(wf)};
    req_read     = rd;
    req_set_mask = mask;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic send_word(logic [31:0] d);
    wr_valid = 1'b1;
    wr_word  = d;
    forever begin
      bit r;
      r = word_ready;
      @(negedge clk);
      if (r) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic pull_word(output logic [31:0] got, output bit seen);
    rd_pull = 1'b1;
    forever begin
      bit r;
      r = word_ready;
      @(negedge clk);
      if (r) break;
    end
    rd_pull = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < 8; t++) begin
      if (rd_valid) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    got = rd_word;
  endtask

  // Sends words for the first nwords of a write transfer (-1 = all).
  task automatic write_words(bit mask, int seed, int nwords);
    int n, total;
    n = pix_a.size();
    total = (n + 1) / 2;
    if (nwords >= 0 && nwords < total) total = nwords;
    for (int k = 0; k < total; k++) begin
      logic [31:0] d;
      logic [15:0] v;
      d = wdat(seed + k);
      v = d[15:0] | (mask ? 16'h8000 : 16'h0000);
      exp_a.push_back(pix_a[2*k]);
      exp_d.push_back(v);
      mdl_fb[pix_a[2*k]] = v;
      if (2*k + 1 < n) begin
        v = d[31:16] | (mask ? 16'h8000 : 16'h0000);
        exp_a.push_back(pix_a[2*k+1]);
        exp_d.push_back(v);
        mdl_fb[pix_a[2*k+1]] = v;
      end
      send_word(d);
    end
  endtask

  task automatic do_write(int x, int y, int wf, int hf, bit mask, int seed, string tag);
    issue(x, y, wf, hf, 1'b0, mask);
    write_words(mask, seed, -1);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0, tag, 32'(exp_a.size()), 32'd0);
    chk(busy == 1'b0, "R8 idle after write", 32'(busy), 32'd0);
  endtask

  // Reads nwords of a read transfer (-1 = all) and checks each word.
  task automatic do_read(int x, int y, int wf, int hf, int nwords, string tag);
    int n, total;
    issue(x, y, wf, hf, 1'b1, 1'b0);
    chk(img_ready == 1'b1, "R7 img_ready raised", 32'(img_ready), 32'd1);
    n = pix_a.size();
    total = (n + 1) / 2;
    if (nwords >= 0 && nwords < total) total = nwords;
    for (int k = 0; k < total; k++) begin
      logic [31:0] got, exp;
      bit seen, fin;
      fin = (2*k + 2 >= n);
      exp[15:0]  = mdl_pix(pix_a[2*k]);
      exp[31:16] = (2*k + 1 < n) ? mdl_pix(pix_a[2*k+1]) : 16'h0000;
      allow_done = fin;
      pull_word(got, seen);
      chk(seen, {tag, " R7 rd_valid seen"}, 32'(seen), 32'd1);
      chk(got == exp, {tag, " R7/R6 read word"}, got, exp);
      if (fin) begin
        chk(done == 1'b1, "R8 done with final read word", 32'(done), 32'd1);
        chk(img_ready == 1'b0, "R7 img_ready cleared", 32'(img_ready), 32'd0);
      end else begin
        chk(img_ready == 1'b1, "R7 img_ready held", 32'(img_ready), 32'd1);
      end
      @(negedge clk);
      allow_done = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk({busy, img_ready, done, word_ready, rd_valid, mem_we, mem_re} == 7'b0,
        "R10 reset outputs", 32'({busy, img_ready, done, word_ready, rd_valid, mem_we, mem_re}), 32'd0);

    // R1 R3: basic write and read back, junk bits ignored
    do_write(5, 7, 3, 2, 1'b0, 10, "R1 R3 basic write");
    do_read(5, 7, 3, 2, -1, "R3 basic read");

    // R5 R6: masked write with odd pixel count, then read back
    do_write(9, 9, 3, 1, 1'b1, 40, "R5 R6 masked odd write");
    do_read(9, 9, 3, 1, -1, "R6 odd read");

    // R4: column wrap and row wrap
    do_write(1022, 3, 4, 2, 1'b0, 70, "R4 column wrap");
    do_read(1022, 3, 4, 2, -1, "R4 column wrap read");
    do_write(0, 510, 2, 4, 1'b0, 90, "R4 row wrap");
    do_read(0, 510, 2, 4, -1, "R4 row wrap read");

    // R2: zero width means 1024 columns, zero height means 512 rows
    do_write(512, 20, 0, 1, 1'b0, 200, "R2 full width");
    do_write(7, 3, 1, 0, 1'b1, 900, "R2 full height");
    do_read(7, 3, 1, 0, -1, "R2 full height read");

    // Read of never-written pixels
    do_read(300, 400, 2, 1, -1, "R3 unwritten read");

    // R9: abort a write mid-transfer; no done, new transfer starts fresh
    issue(100, 50, 4, 4, 1'b0, 1'b0);
    write_words(1'b0, 500, 1);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0, "R9 partial writes made", 32'(exp_a.size()), 32'd0);
    chk(busy == 1'b1, "R9 still busy mid-transfer", 32'(busy), 32'd1);
    do_write(200, 60, 2, 1, 1'b0, 600, "R9 restarted write");

    // R9: abort a read; a write request clears img_ready
    do_read(5, 7, 4, 1, 1, "R9 partial read");
    chk(img_ready == 1'b1, "R9 read pending", 32'(img_ready), 32'd1);
    issue(40, 41, 1, 1, 1'b0, 1'b0);
    chk(img_ready == 1'b0, "R9 img_ready dropped on new request", 32'(img_ready), 32'd0);
    write_words(1'b0, 700, -1);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0, "R9 write after aborted read", 32'(exp_a.size()), 32'd0);

    repeat (5) @(negedge clk);
    report();
    $finish;
  end

endmodule